// File: doc/BRIEF.md
# Programmable Envelope Shape Generator

This block produces a 4-bit envelope level that a sound datapath uses to modulate the amplitude of its channels. It divides its clock by 256 and then by a 16-bit programmed period. Each resulting step tick moves a 4-bit level counter by one position. A 4-bit shape code sets four things: the starting direction, whether the pattern runs once or repeats, whether repeats reverse direction, and whether the level freezes once the first sweep ends.

A one-cycle restart strobe, pulsed by the register logic whenever the shape code is written, clears both dividers and loads the starting level for the new shape. The shape code and the period are read live from the inputs. The top-level bus decoding and the channel mixing sit outside this block.

The step logic is a state machine with three states. `ENV_FROZEN` ignores step ticks. `ENV_RUN_UP` raises the level by one on each tick. `ENV_RUN_DOWN` lowers the level by one on each tick. The transitions are:

- T_RESTART: any state goes to the starting sweep.
- T_STEP: one position within a sweep.
- T_WRAP_STOP: drop to 0 and freeze.
- T_WRAP_HOLD: freeze at an extreme.
- T_WRAP_REPEAT: restart the same sweep.
- T_WRAP_REVERSE: swap the sweep direction and keep the extreme level.

Top module: `env_shape_gen`

## Requirements
- R1: While reset is low, and after reset until the first restart strobe, the level is 0 and stays 0.
- R2: After a restart edge, the level changes for the first time exactly 256*P clock edges later, and then every 256*P edges, where P is the period input.
- R3: A period of 0 gives the same step interval as a period of 1 (256 clocks).
- R4: The shape code has these bit positions: bit 3 = continue, bit 2 = attack, bit 1 = alternate, bit 0 = hold. On a restart, attack=1 loads level 0 and counts up; attack=0 loads level 15 and counts down. Each step moves the level by exactly one position.
- R5: With continue=0, the step after the first sweep ends sets the level to 0, and the level stays 0 until the next restart, whatever the other bits are.
- R6: With continue=1, hold=1 and alternate=0, the level freezes at the sweep's final value: 15 when counting up, 0 when counting down.
- R7: With continue=1, hold=1 and alternate=1, the level freezes at the opposite extreme: 0 after an up sweep, 15 after a down sweep.
- R8: With continue=1, hold=0 and alternate=0, the sweep repeats. The step after the final value returns to the starting value.
- R9: With continue=1, hold=0 and alternate=1, the direction reverses at each sweep end. The extreme value is held for one extra step interval before the new sweep moves away from it.
- R10: A restart in the same cycle as a step tick takes priority: the starting level is loaded, the step is discarded, and the next step comes a full 256*P edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period | input | 16 | Step period in units of 256 clocks (0 is treated as 1) |
| shape | input | 4 | Shape code: continue, attack, alternate, hold (bits 3..0) |
| restart | input | 1 | One-cycle strobe that restarts the envelope |
| level | output | 4 | Current envelope level |

## Verification
The restart strobe and a step tick can land on the same clock edge. That is the one point where two state updates compete for the level register. The bench provokes this by restarting with an up-counting shape and waiting exactly 255 edges. On the 256th edge, the edge on which the first step would fire, it raises restart with a down-counting shape. A correct design then shows 15 rather than 1, and its next change comes a full interval later. This is judged both by an explicit check and by the cycle-by-cycle reference model, which gives restart priority.

// File: rtl/env_pkg.sv
package env_pkg;

    // Step state machine states
    typedef enum logic [1:0] {
        ENV_FROZEN   = 2'd0,
        ENV_RUN_UP   = 2'd1,
        ENV_RUN_DOWN = 2'd2
    } env_state_t;

    // Shape code fields; packed order matches bit positions 3..0
    typedef struct packed {
        logic cont;
        logic attack;
        logic alt;
        logic hold;
    } env_shape_t;

endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;
    localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRE_ONE;
        end
    end

    assign tick = (cnt_q == PRE_LAST) && !clear;

endmodule

// File: rtl/env_period_ctr.sv
module env_period_ctr #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                pre_tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                step
);
    localparam logic [PERIOD_W-1:0] P_ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] last_idx;
    logic                at_last;

    // Period 0 behaves as period 1: last index is 0 in both cases
    always_comb begin
        if (period == '0) begin
            last_idx = '0;
        end else begin
            last_idx = period - P_ONE;
        end
    end

    // Greater-or-equal guards against a period lowered mid-count
    assign at_last = (cnt_q >= last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            if (at_last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + P_ONE;
            end
        end
    end

    assign step = pre_tick && at_last;

endmodule

// File: rtl/env_step_fsm.sv
module env_step_fsm
    import env_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  env_shape_t       shape,
    output logic [LVL_W-1:0] level,
    output env_state_t       state
);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] LVL_MIN = '0;
    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

    env_state_t       state_q, state_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             going_up;
    logic             at_end;

    assign going_up = (state_q == ENV_RUN_UP);
    assign at_end   = going_up ? (lvl_q == LVL_MAX) : (lvl_q == LVL_MIN);

    // Next-state and next-level decision
    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        if (restart) begin
            // T_RESTART
            state_d = shape.attack ? ENV_RUN_UP : ENV_RUN_DOWN;
            lvl_d   = shape.attack ? LVL_MIN : LVL_MAX;
        end else if (step) begin
            unique case (state_q)
                ENV_FROZEN: begin
                    state_d = ENV_FROZEN;
                    lvl_d   = lvl_q;
                end
                ENV_RUN_UP, ENV_RUN_DOWN: begin
                    if (!at_end) begin
                        // T_STEP
                        lvl_d = going_up ? (lvl_q + LVL_ONE) : (lvl_q - LVL_ONE);
                    end else if (!shape.cont) begin
                        // T_WRAP_STOP
                        state_d = ENV_FROZEN;
                        lvl_d   = LVL_MIN;
                    end else if (shape.hold) begin
                        // T_WRAP_HOLD
                        state_d = ENV_FROZEN;
                        lvl_d   = (shape.alt ^ going_up) ? LVL_MAX : LVL_MIN;
                    end else if (shape.alt) begin
                        // T_WRAP_REVERSE: extreme level is kept one more interval
                        state_d = going_up ? ENV_RUN_DOWN : ENV_RUN_UP;
                        lvl_d   = lvl_q;
                    end else begin
                        // T_WRAP_REPEAT
                        state_d = state_q;
                        lvl_d   = going_up ? LVL_MIN : LVL_MAX;
                    end
                end
                default: begin
                    state_d = ENV_FROZEN;
                    lvl_d   = LVL_MIN;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENV_FROZEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= LVL_MIN;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign level = lvl_q;
    assign state = state_q;

endmodule

// File: rtl/env_shape_gen.sv
module env_shape_gen
    import env_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int PRE_W    = 8,
    parameter int LVL_W    = 4,
    parameter int SHAPE_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic [SHAPE_W-1:0]  shape,
    input  logic                restart,
    output logic [LVL_W-1:0]    level
);
    logic       pre_tick;
    logic       step_w;
    env_state_t fsm_state;
    env_shape_t shape_s;

    assign shape_s = env_shape_t'(shape[3:0]);

    env_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (pre_tick)
    );

    env_period_ctr #(.PERIOD_W(PERIOD_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .pre_tick (pre_tick),
        .period   (period),
        .step     (step_w)
    );

    env_step_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (step_w),
        .shape   (shape_s),
        .level   (level),
        .state   (fsm_state)
    );

endmodule

// File: rtl/env_shape_chk.sv
module env_shape_chk
    import env_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       step,
    input logic [3:0] shape,
    input logic [3:0] level,
    input env_state_t state
);
    // R1: level is zero on leaving reset
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (level == 4'd0));

    // R2: without restart or step the level does not move
    a_r2_no_move_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step) |=> $stable(level));

    // R4: restart loads the starting level from the attack bit
    a_r4_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (level == ($past(shape[2]) ? 4'd0 : 4'd15)));

    // R4: an up step inside a sweep adds exactly one
    a_r4_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && state == ENV_RUN_UP && level != 4'd15)
        |=> (level == $past(level) + 4'd1));

    // R5: end of a sweep with continue clear drops to zero and freezes
    a_r5_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !shape[3] &&
         ((state == ENV_RUN_UP && level == 4'd15) || (state == ENV_RUN_DOWN && level == 4'd0)))
        |=> (level == 4'd0 && state == ENV_FROZEN));

    // R6: a frozen level ignores further steps
    a_r6_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENV_FROZEN && !restart) |=> $stable(level));

endmodule

bind env_shape_gen env_shape_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step_w),
    .shape   (shape),
    .level   (level),
    .state   (fsm_state)
);

// File: tb/env_shape_gen_tb.sv
module env_shape_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period = 16'd1;
    logic [3:0]  shape = 4'd0;
    logic        restart = 1'b0;
    logic [3:0]  level;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0;
    int m_lvl = 0;
    bit m_up = 0;
    bit m_frz = 1;

    always #2 clk = ~clk;

    env_shape_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period),
        .shape   (shape),
        .restart (restart),
        .level   (level)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s level actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_advance();
        bit ended;
        ended = m_up ? (m_lvl == 15) : (m_lvl == 0);
        if (!ended) begin
            m_lvl = m_up ? m_lvl + 1 : m_lvl - 1;
        end else if (!shape[3]) begin
            m_lvl = 0;
            m_frz = 1;
        end else if (shape[0]) begin
            m_frz = 1;
            m_lvl = (shape[1] ^ m_up) ? 15 : 0;
        end else if (shape[1]) begin
            m_up = !m_up;
        end else begin
            m_lvl = m_up ? 0 : 15;
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic tick();
        int eff;
        @(posedge clk);
        if (!rst_n) begin
            m_lvl = 0;
            m_frz = 1;
            m_cnt = 0;
        end else if (restart) begin
            m_cnt = 0;
            m_up  = shape[2];
            m_lvl = m_up ? 0 : 15;
            m_frz = 0;
        end else begin
            eff = (period == 16'd0) ? 1 : int'(period);
            m_cnt++;
            if (m_cnt >= 256 * eff) begin
                m_cnt = 0;
                if (!m_frz) model_advance();
            end
        end
        @(negedge clk);
        check(cur_req, int'(level), m_lvl);
    endtask

    task automatic start(input logic [3:0] shp, input logic [15:0] per);
        shape   = shp;
        period  = per;
        restart = 1'b1;
        tick();
        restart = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // count edges from a restart until the level first changes
    task automatic measure(input logic [3:0] shp, input logic [15:0] per, output int edges);
        int first;
        start(shp, per);
        first = int'(level);
        edges = 1;
        while (int'(level) == first && edges < 70000) begin
            tick();
            edges++;
        end
        edges = edges - 1;
    endtask

    initial begin
        int edges;
        @(negedge clk);
        cur_req = "R1";
        run(4);
        check("R1", int'(level), 0);
        rst_n = 1'b1;
        run(700);
        check("R1", int'(level), 0);

        cur_req = "R2";
        measure(4'b1100, 16'd3, edges);
        check("R2", edges, 768);
        run(1600);

        cur_req = "R3";
        measure(4'b1100, 16'd0, edges);
        check("R3", edges, 256);
        measure(4'b1100, 16'd1, edges);
        check("R3", edges, 256);

        cur_req = "R8";
        start(4'b1100, 16'd1);
        run(4096 * 2 + 600);
        start(4'b1000, 16'd1);
        run(4096 * 2 + 600);

        cur_req = "R9";
        start(4'b1110, 16'd1);
        run(4096 * 2 + 600);
        start(4'b1010, 16'd1);
        run(4096 * 2 + 600);

        cur_req = "R6";
        start(4'b1101, 16'd1);
        run(4096 + 1200);
        check("R6", int'(level), 15);
        start(4'b1001, 16'd1);
        run(4096 + 1200);
        check("R6", int'(level), 0);

        cur_req = "R7";
        start(4'b1111, 16'd1);
        run(4096 + 1200);
        check("R7", int'(level), 0);
        start(4'b1011, 16'd1);
        run(4096 + 1200);
        check("R7", int'(level), 15);

        cur_req = "R5";
        start(4'b0100, 16'd1);
        run(4096 + 1200);
        check("R5", int'(level), 0);
        start(4'b0111, 16'd1);
        run(4096 + 1200);
        check("R5", int'(level), 0);
        start(4'b0000, 16'd1);
        run(4096 + 1200);
        check("R5", int'(level), 0);

        cur_req = "R4";
        start(4'b0100, 16'd1);
        check("R4", int'(level), 0);
        run(256);
        check("R4", int'(level), 1);
        start(4'b0000, 16'd1);
        check("R4", int'(level), 15);
        run(256);
        check("R4", int'(level), 14);

        // R10: restart lands on the same edge as the first step
        cur_req = "R10";
        start(4'b1100, 16'd1);
        run(255);
        start(4'b1000, 16'd1);
        check("R10", int'(level), 15);
        run(255);
        check("R10", int'(level), 15);
        run(1);
        check("R10", int'(level), 14);
        run(600);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 195000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule